// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master fed through a four-entry transmit queue of 32-bit command words. Every command word holds the frame data together with its own control bits. These bits pick the chip select and the attribute set, decide whether chip select stays asserted after the frame, mark the end of a queue, and can clear the frame counter before the frame is sent. Each attribute set gives a frame length of 4 to 16 bits, a clock polarity, a clock phase and a bit order. Every received frame lands right-justified in a four-entry receive FIFO, which software pops.

Software loads attribute sets and the control register through a simple write port, then pushes command words. Frames run back to back until the queue drains or the halt bit is set. When a frame marked end-of-queue completes, a sticky flag is raised. That flag drives the interrupt if its enable is on, and it is cleared by writing one to it. The frame counter and both FIFO levels are available as plain outputs. SCK runs at one half-period per `HALF` clocks.

Write map by `reg_addr`:
- 0: control. Bit 0 halts, bit 1 flushes TX (pulse), bit 2 flushes RX (pulse), bit 3 enables the interrupt, bits 16 and up give the idle level of each chip select.
- 1: status, write-one-to-clear. Bit 0 is end-of-queue, bit 1 is overflow.
- 2: push a command word.
- 4 + n: attribute set n.

Top module: `qspi_master`

## Requirements
- R1: The TX and RX FIFOs each hold 4 entries. `tx_level` and `rx_level` are 0 after reset. A push to a full TX FIFO is ignored.
- R2: A frame lasts 2*N half-periods of `HALF` clocks each, so `busy` is high for 2*N*HALF cycles. N is attribute bits [3:0] plus one, and a field value below 3 is treated as 3 (4 bits).
- R3: Attribute bit 4 is CPOL and bit 5 is CPHA. MOSI presents bit j during half-periods 2j and 2j+1. MISO is sampled when half-period 2j ends. SCK equals CPOL^CPHA^(half-period index mod 2). Bit 6 set sends and receives LSB first; clear sends MSB first.
- R4: `rx_data` holds the head RX entry right-justified, with bits [31:16] zero. It reads 0 when the FIFO is empty.
- R5: Command bits [19:16] select the chip select. While a frame is active, that chip select drives the inverse of its idle level. If command bit 24 (continuous) is clear, it returns to idle when the frame ends. If bit 24 is set, it stays active until a later frame ends with bit 24 clear.
- R6: Command bit 25 sets `eoq_flag` at the clock that ends its frame. `irq` is `eoq_flag` AND control bit 3. Writing 1 to status bit 0 clears the flag, and a set on the same clock wins.
- R7: Command bit 26 clears `xfer_cnt` when its frame starts. `xfer_cnt` increases by one at the end of every frame.
- R8: While halt is set, or while the TX FIFO is empty, no frame starts, and SCK stays at the CPOL of the last frame (0 after reset). A frame that is already running completes.
- R9: If the RX FIFO holds 4 entries when a frame ends, the frame is dropped and `ovf_flag` is set. Writing 1 to status bit 1 clears it.
- R10: Writing control bit 1 empties the TX FIFO. Writing control bit 2 empties the RX FIFO.
- R11: Command bits [20 +: AW] choose which attribute set the frame uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| rx_pop | input | 1 | Pops the head RX entry |
| rx_data | output | 32 | Head RX entry, right-justified |
| tx_level | output | $clog2(DEPTH)+1 | TX FIFO occupancy |
| rx_level | output | $clog2(DEPTH)+1 | RX FIFO occupancy |
| eoq_flag | output | 1 | End-of-queue status flag |
| ovf_flag | output | 1 | RX overflow status flag |
| irq | output | 1 | Interrupt request |
| xfer_cnt | output | CNT_W | Frame counter |
| busy | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | NCS | Chip selects, idle level set per line |

## Verification
A pushed command reaches `tx_level` on the next clock edge. When the queue is idle and not halted, its frame starts one edge later; `busy`, the chip select and the first MOSI bit all change on that edge. The RX entry, the counter increment, the end-of-queue and overflow flags, and the chip-select release all appear on the edge that ends half-period 2N-1, and a W1C write takes effect on the edge that samples it. The bench keeps a behavioural model that takes the same inputs on every rising edge. It compares every output on the falling edge, after all registers have settled, and directed checks measure frame length, halt and flush effects at the same falling-edge points.

// File: rtl/qspi_master.sv
module qspi_master #(
  parameter int NCS   = 4,
  parameter int NATTR = 2,
  parameter int DEPTH = 4,
  parameter int HALF  = 2,
  parameter int CNT_W = 16
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [2:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  input  logic                      rx_pop,
  output logic [31:0]               rx_data,
  output logic [$clog2(DEPTH):0]    tx_level,
  output logic [$clog2(DEPTH):0]    rx_level,
  output logic                      eoq_flag,
  output logic                      ovf_flag,
  output logic                      irq,
  output logic [CNT_W-1:0]          xfer_cnt,
  output logic                      busy,
  output logic                      sck,
  output logic                      mosi,
  input  logic                      miso,
  output logic [NCS-1:0]            cs_out
);
  localparam int PW = $clog2(DEPTH);
  localparam int AW = (NATTR > 1) ? $clog2(NATTR) : 1;
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CW = 23 + AW;
  localparam int A_ATTR = 4;

  logic          halt, ie;
  logic [NCS-1:0] idle_lvl;
  logic [6:0]    attr [NATTR];
  logic [CW-1:0] txf [DEPTH];
  logic [15:0]   rxf [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [PW:0]   tx_n, rx_n;

  logic          run, pol_q, pha_q, lsb_q, cont_q, eoq_q, cs_on;
  logic [4:0]    k;
  logic [HW-1:0] h;
  logic [3:0]    nb_m1, cs_idx, bitpos;
  logic [15:0]   txd, rxd;

  wire wr_ctrl = reg_we && reg_addr == 3'd0;
  wire wr_stat = reg_we && reg_addr == 3'd1;
  wire push    = reg_we && reg_addr == 3'd2 && tx_n != (PW+1)'(DEPTH);
  wire fl_tx   = wr_ctrl && reg_wdata[1];
  wire fl_rx   = wr_ctrl && reg_wdata[2];

  wire [CW-1:0] head  = txf[tx_rp];
  wire [6:0]    hattr = attr[head[20 +: AW]];
  wire start    = !run && !halt && tx_n != '0;
  wire half_end = run && h == HW'(HALF-1);
  wire last     = half_end && k == {nb_m1, 1'b1};
  wire rx_full  = rx_n == (PW+1)'(DEPTH);
  wire rx_put   = last && !rx_full;
  wire rx_take  = rx_pop && rx_n != '0;

  assign bitpos   = lsb_q ? k[4:1] : nb_m1 - k[4:1];
  assign mosi     = run & txd[bitpos];
  assign sck      = run ? (pol_q ^ pha_q ^ k[0]) : pol_q;
  assign busy     = run;
  assign tx_level = tx_n;
  assign rx_level = rx_n;
  assign rx_data  = (rx_n != '0) ? {16'h0, rxf[rx_rp]} : 32'h0;
  assign irq      = eoq_flag & ie;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_out[i] = (cs_on && cs_idx == 4'(i)) ? ~idle_lvl[i] : idle_lvl[i];
  end

  // registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b0; ie <= 1'b0; idle_lvl <= '1;
      eoq_flag <= 1'b0; ovf_flag <= 1'b0;
      for (int i = 0; i < NATTR; i++) attr[i] <= 7'h07;
    end else begin
      if (wr_ctrl) begin
        halt <= reg_wdata[0];
        ie <= reg_wdata[3];
        idle_lvl <= reg_wdata[16 +: NCS];
      end
      for (int i = 0; i < NATTR; i++)
        if (reg_we && reg_addr == 3'(A_ATTR + i)) attr[i] <= reg_wdata[6:0];
      eoq_flag <= (last && eoq_q) | (eoq_flag & ~(wr_stat & reg_wdata[0]));
      ovf_flag <= (last && rx_full) | (ovf_flag & ~(wr_stat & reg_wdata[1]));
    end
  end

  // transmit FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_n <= '0;
    end else if (fl_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_n <= '0;
    end else begin
      if (push) begin
        txf[tx_wp] <= {reg_wdata[26:24], reg_wdata[20 +: AW], reg_wdata[19:0]};
        tx_wp <= tx_wp + PW'(1);
      end
      if (start) tx_rp <= tx_rp + PW'(1);
      if (push && !start) tx_n <= tx_n + (PW+1)'(1);
      else if (!push && start) tx_n <= tx_n - (PW+1)'(1);
    end
  end

  // receive FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_n <= '0;
    end else if (fl_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_n <= '0;
    end else begin
      if (rx_put) begin
        rxf[rx_wp] <= rxd;
        rx_wp <= rx_wp + PW'(1);
      end
      if (rx_take) rx_rp <= rx_rp + PW'(1);
      if (rx_put && !rx_take) rx_n <= rx_n + (PW+1)'(1);
      else if (!rx_put && rx_take) rx_n <= rx_n - (PW+1)'(1);
    end
  end

  // shift engine and chip select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; k <= '0; h <= '0; txd <= '0; rxd <= '0; nb_m1 <= 4'd7;
      pol_q <= 1'b0; pha_q <= 1'b0; lsb_q <= 1'b0; cont_q <= 1'b0; eoq_q <= 1'b0;
      cs_on <= 1'b0; cs_idx <= '0; xfer_cnt <= '0;
    end else if (start) begin
      run <= 1'b1; k <= '0; h <= '0; rxd <= '0;
      txd <= head[15:0];
      cs_idx <= head[19:16];
      cont_q <= head[20+AW];
      eoq_q <= head[21+AW];
      if (head[22+AW]) xfer_cnt <= '0;
      nb_m1 <= (hattr[3:0] < 4'd3) ? 4'd3 : hattr[3:0];
      pol_q <= hattr[4]; pha_q <= hattr[5]; lsb_q <= hattr[6];
      cs_on <= 1'b1;
    end else if (half_end) begin
      h <= '0;
      k <= k + 5'd1;
      if (!k[0]) rxd[bitpos] <= miso;
      if (last) begin
        run <= 1'b0;
        xfer_cnt <= xfer_cnt + CNT_W'(1);
        if (!cont_q) cs_on <= 1'b0;
      end
    end else if (run) begin
      h <= h + HW'(1);
    end
  end
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
  parameter int NCS = 4, DEPTH = 4, CNT_W = 16
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run,
  input logic                   halt,
  input logic                   sck,
  input logic [NCS-1:0]         cs_out,
  input logic [NCS-1:0]         idle_lvl,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic                   eoq_flag,
  input logic                   ovf_flag,
  input logic [CNT_W-1:0]       xfer_cnt
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= DEPTH) && (rx_level <= DEPTH));
  p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_out ^ idle_lvl));
  p_eoq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoq_flag) |-> $past(run));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> xfer_cnt == $past(xfer_cnt) + CNT_W'(1));
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !run) |=> !run);
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0 && !run) |=> !run);
  p_sck_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> $stable(sck));
  p_ovf_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(rx_level) == DEPTH);
endmodule

bind qspi_master qspi_master_chk #(.NCS(NCS), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .halt(halt), .sck(sck), .cs_out(cs_out),
  .idle_lvl(idle_lvl), .tx_level(tx_level), .rx_level(rx_level),
  .eoq_flag(eoq_flag), .ovf_flag(ovf_flag), .xfer_cnt(xfer_cnt));

// File: tb/qspi_master_test.sv
module qspi_master_test;
  localparam int DEPTH = 4;
  localparam int HALF  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rx_data;
  logic [2:0] tx_level, rx_level;
  logic eoq_flag, ovf_flag, irq, busy, sck, mosi;
  logic [15:0] xfer_cnt;
  logic [3:0] cs_out;

  int compared = 0, mismatched = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  qspi_master uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_pop(rx_pop), .rx_data(rx_data), .tx_level(tx_level),
    .rx_level(rx_level), .eoq_flag(eoq_flag), .ovf_flag(ovf_flag), .irq(irq),
    .xfer_cnt(xfer_cnt), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .cs_out(cs_out));

  always @(negedge clk) begin
    miso <= lfsr[0];
    lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  // reference model state
  logic [31:0] txq[$];
  logic [15:0] rxq[$];
  bit m_live = 0, m_halt, m_ie, m_run, m_p, m_ph, m_l, m_cont, m_eo, m_cs_on, m_eoq, m_ovf;
  bit [3:0] m_idle;
  int m_fsz[2], m_pol[2], m_pha[2], m_lsb[2];
  int m_k, m_h, m_nb, m_cs, m_cnt;
  logic [15:0] m_word, m_rx;

  function automatic int bp(int kk);
    return m_l ? kk / 2 : m_nb - 1 - kk / 2;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] w;
    bit st, hend, dn, full, pok, s_eoq, s_ovf;
    int a;
    m_live = 1;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_halt = 0; m_ie = 0; m_idle = 4'hF; m_run = 0; m_p = 0; m_ph = 0; m_l = 0;
      m_cont = 0; m_eo = 0; m_cs_on = 0; m_eoq = 0; m_ovf = 0;
      m_k = 0; m_h = 0; m_nb = 8; m_cs = 0; m_cnt = 0; m_word = 0; m_rx = 0;
      for (int i = 0; i < 2; i++) begin m_fsz[i] = 7; m_pol[i] = 0; m_pha[i] = 0; m_lsb[i] = 0; end
    end else begin
      st = !m_run && !m_halt && txq.size() > 0;
      hend = m_run && m_h == HALF - 1;
      dn = hend && m_k == 2 * m_nb - 1;
      full = rxq.size() == DEPTH;
      pok = txq.size() != DEPTH;
      s_eoq = 0; s_ovf = 0;
      if (rx_pop && rxq.size() > 0) void'(rxq.pop_front());
      if (dn) begin
        if (full) s_ovf = 1;
        else rxq.push_back(m_rx);
      end
      if (st) begin
        w = txq.pop_front();
        a = w[20];
        m_run = 1; m_k = 0; m_h = 0; m_rx = 0; m_word = w[15:0];
        m_nb = (m_fsz[a] < 3 ? 3 : m_fsz[a]) + 1;
        m_p = m_pol[a][0]; m_ph = m_pha[a][0]; m_l = m_lsb[a][0];
        m_cont = w[24]; m_eo = w[25]; m_cs_on = 1; m_cs = w[19:16];
        if (w[26]) m_cnt = 0;
      end else if (m_run) begin
        if (hend) begin
          m_h = 0;
          if (m_k % 2 == 0) m_rx[bp(m_k)] = miso;
          if (dn) begin
            m_run = 0; m_cnt = (m_cnt + 1) % 65536;
            if (!m_cont) m_cs_on = 0;
            if (m_eo) s_eoq = 1;
          end
          m_k++;
        end else m_h++;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            m_halt = reg_wdata[0]; m_ie = reg_wdata[3]; m_idle = reg_wdata[19:16];
            if (reg_wdata[1]) txq.delete();
            if (reg_wdata[2]) rxq.delete();
          end
          3'd1: begin
            if (reg_wdata[0]) m_eoq = 0;
            if (reg_wdata[1]) m_ovf = 0;
          end
          3'd2: if (pok) txq.push_back(reg_wdata);
          3'd4, 3'd5: begin
            a = int'(reg_addr) - 4;
            m_fsz[a] = reg_wdata[3:0]; m_pol[a] = reg_wdata[4];
            m_pha[a] = reg_wdata[5]; m_lsb[a] = reg_wdata[6];
          end
          default: ;
        endcase
      end
      if (s_eoq) m_eoq = 1;
      if (s_ovf) m_ovf = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin : compare
    logic [3:0] ecs;
    if (m_live) begin
      for (int i = 0; i < 4; i++) ecs[i] = (m_cs_on && m_cs == i) ? !m_idle[i] : m_idle[i];
      chk("R2 busy", 32'(busy), 32'(m_run));
      chk("R3 sck", 32'(sck), 32'(m_run ? (m_p ^ m_ph ^ m_k[0]) : m_p));
      chk("R3 mosi", 32'(mosi), 32'(m_run ? m_word[bp(m_k)] : 1'b0));
      chk("R5 cs_out", 32'(cs_out), 32'(ecs));
      chk("R1 tx_level", 32'(tx_level), 32'(txq.size()));
      chk("R1 rx_level", 32'(rx_level), 32'(rxq.size()));
      chk("R4 rx_data", rx_data, rxq.size() > 0 ? {16'h0, rxq[0]} : 32'h0);
      chk("R6 eoq_flag", 32'(eoq_flag), 32'(m_eoq));
      chk("R6 irq", 32'(irq), 32'(m_eoq & m_ie));
      chk("R9 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
      chk("R7 xfer_cnt", 32'(xfer_cnt), 32'(m_cnt));
    end
  end

  function automatic logic [31:0] cmd(int d, int cs, int at, bit cont, bit eoq, bit clr);
    return {5'b0, clr, eoq, cont, 2'b0, 2'(at), 4'(cs), 16'(d)};
  endfunction

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(addr); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy && tx_level == 0) break;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R2: actual frames still pending, expected completion");
    finish_run();
  end

  initial begin : stim
    int n;
    repeat (4) @(negedge clk);
    chk("R1 tx_level after reset", 32'(tx_level), 0);
    chk("R1 rx_level after reset", 32'(rx_level), 0);
    rst_n = 1;
    @(negedge clk);
    // mode 0, MSB first, continuous chip select, end of queue
    wr(0, 32'h000F0008);
    wr(2, cmd(16'hA5, 0, 0, 1, 0, 1));
    wr(2, cmd(16'h3C, 0, 0, 1, 0, 0));
    wr(2, cmd(16'hF0, 0, 0, 0, 1, 0));
    wait_idle();
    chk("R6 eoq set", 32'(eoq_flag), 1);
    chk("R7 counter after three frames", 32'(xfer_cnt), 3);
    wr(1, 32'h1);
    @(negedge clk);
    chk("R6 eoq cleared by W1C", 32'(eoq_flag), 0);
    chk("R4 upper bits zero", 32'(rx_data[31:16]), 0);
    repeat (3) pop();
    // attribute set 1: 12 bits, CPOL1 CPHA1, LSB first, active-high cs2
    wr(5, 32'h0000007B);
    wr(0, 32'h000B0008);
    wr(2, cmd(16'h0ABC, 2, 1, 1, 0, 0));
    wr(2, cmd(16'h0123, 2, 1, 0, 1, 0));
    wait_idle();
    chk("R11 sck rests at attr1 CPOL", 32'(sck), 1);
    repeat (2) pop();
    // short frame: field 1 clamps to 4 bits, CPHA1
    wr(0, 32'h000F0008);
    wr(4, 32'h00000021);
    wr(2, cmd(16'h9, 3, 0, 0, 0, 0));
    while (!busy) @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R2 clamped frame length", 32'(n), 32'(2 * 4 * HALF));
    pop();
    wr(4, 32'h00000007);
    // overflow: five frames without pops
    for (int i = 0; i < 5; i++) wr(2, cmd(16'h11 * (i + 1), 1, 0, i != 4, 0, 0));
    wait_idle();
    chk("R9 overflow flag", 32'(ovf_flag), 1);
    chk("R9 rx full", 32'(rx_level), 4);
    wr(1, 32'h2);
    @(negedge clk);
    chk("R9 overflow cleared", 32'(ovf_flag), 0);
    wr(0, 32'h000F000C);
    @(negedge clk);
    chk("R10 rx flushed", 32'(rx_level), 0);
    // halt holds the queue
    wr(0, 32'h000F0009);
    wr(2, cmd(16'h77, 0, 0, 0, 0, 0));
    wr(2, cmd(16'h66, 0, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk("R8 no start while halted", 32'(busy), 0);
    chk("R8 queue kept while halted", 32'(tx_level), 2);
    chk("R8 sck rests at CPOL", 32'(sck), 0);
    for (int i = 0; i < 3; i++) wr(2, cmd(16'h55, 0, 0, 0, 0, 0));
    chk("R1 push to full ignored", 32'(tx_level), 4);
    wr(0, 32'h000F000B);
    @(negedge clk);
    chk("R10 tx flushed", 32'(tx_level), 0);
    wr(0, 32'h000F0008);
    repeat (10) @(negedge clk);
    chk("R8 empty queue stays idle", 32'(busy), 0);
    // counter clear on a later frame
    wr(2, cmd(16'h5A, 0, 0, 0, 1, 1));
    wait_idle();
    chk("R7 counter cleared then counted", 32'(xfer_cnt), 1);
    chk("R6 irq with enable", 32'(irq), 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule